// File: doc/BRIEF.md
# Word-Fetch Pixel Serializer

This block turns a one-bit-per-pixel display plane into a serial pixel stream. Memory is never read one pixel at a time. A word counter walks each scan line and issues one aligned fetch for every word period. Each fetched word goes into a holding register and then into a shift register. The shift register gives one pixel per dot clock, leftmost pixel first. Because a word covers `WORD_W` dots, the memory only has to finish one full cycle per word period, not one per dot.

A line begins with a `line_start` pulse during blanking. That pulse resets the word counter and prefetches word 0, so the first word is ready before the first visible dot. From then on, each word is requested when the one before it enters the shift register. The new word therefore has a whole word period to arrive, and the stream has no gap between words. Below the word index, the dot position lives only as the shift phase inside the register.

If a word has not arrived by the time it must load, the block does three things. It shows that word as dark pixels. It flags the event. It throws away the late data when it finally arrives, so that later words stay aligned.

Top module: `pixel_word_serializer`

## Requirements
- R1: Each visible word is output most significant bit first, one pixel per dot. Consecutive words of a line follow with no idle dot between them.
- R2: Fetches are word aligned. The fetch address is the line index concatenated above the word index, and the low log2(`WORD_W`) dot bits never appear in it. A line of `LINE_PIX` dots issues exactly `LINE_PIX/WORD_W` fetches, one per word period.
- R3: In the cycle after `line_start`, `fetch_req` is high for one cycle and the word-index field of `fetch_addr` is zero.
- R4: While `blank` is high, `pix_out` and `underrun` are 0 in the following cycle. No fetch is issued, except the prefetch triggered by `line_start`.
- R5: If a word has not been captured by the dot on which it must load, then all `WORD_W` pixels of that word are 0, and `underrun` is 1 on that word's first dot only. The late data is then discarded and never shown.
- R6: Each `line_start` moves to the next line index. After index `LINES-1` it wraps to 0.
- R7: A `frame_start` asserted together with `line_start` makes that line index 0.
- R8: After reset, `fetch_req`, `pix_out` and `underrun` are 0.
- R9: The pixel for a visible dot (a cycle in which `blank` is low) appears on `pix_out` one clock later. The first visible dot after blanking shows bit `WORD_W-1` of word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Restart line numbering at 0 (used together with line_start) |
| line_start | input | 1 | One-cycle pulse during blanking that begins a new line |
| blank | input | 1 | High outside the visible part of a line |
| fetch_req | output | 1 | One-cycle fetch request strobe |
| fetch_addr | output | ADDR_W | Word address: line index above word index |
| rd_valid | input | 1 | Fetched word is present on rd_data (returned in request order) |
| rd_data | input | WORD_W | Fetched word |
| pix_out | output | 1 | Serial pixel, registered |
| underrun | output | 1 | High on the first dot of a word that arrived too late |

## Verification
Suppose the shift phase is off by a dot. Every word boundary then shows a wrong, duplicated or missing pixel, and this is visible within one word period of the first visible dot. A wrong word or line counter shows up at the port as a wrong `fetch_addr`, or as a wrong fetch count at the end of the line. The pixels returned for that address also differ at once from the expected bits. A drop flag that stays set, or is never set, has a delayed effect. After an underrun it either hides a good word or shows stale data one word later. So the slow-memory line is followed by normal lines, and those are checked pixel by pixel.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

  // Width of an index able to hold 0..count-1, never less than one bit.
  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/pxs_fetch_seq.sv
module pxs_fetch_seq #(
  parameter int WORDS  = 64,
  parameter int LINES  = 1024,
  parameter int WIDX_W = 6,
  parameter int LIDX_W = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     frame_start,
  input  logic                     line_start,
  input  logic                     load_tick,
  output logic                     fetch_req,
  output logic [LIDX_W+WIDX_W-1:0] fetch_addr
);

  localparam logic [LIDX_W-1:0] LAST_LINE = LIDX_W'(LINES - 1);
  localparam logic [WIDX_W:0]   WORDS_C   = (WIDX_W+1)'(WORDS);

  logic [LIDX_W-1:0] line_q;
  logic [LIDX_W-1:0] next_line;
  logic [WIDX_W:0]   word_q;

  always_comb begin
    if (frame_start || line_q == LAST_LINE) next_line = '0;
    else                                    next_line = line_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_req  <= 1'b0;
      fetch_addr <= '0;
      word_q     <= WORDS_C;
      line_q     <= LAST_LINE;
    end else begin
      fetch_req <= 1'b0;
      if (line_start) begin
        fetch_req  <= 1'b1;
        fetch_addr <= {next_line, {WIDX_W{1'b0}}};
        word_q     <= (WIDX_W+1)'(1);
        line_q     <= next_line;
      end else begin
        if (frame_start) line_q <= LAST_LINE;
        if (load_tick && word_q < WORDS_C) begin
          fetch_req  <= 1'b1;
          fetch_addr <= {line_q, word_q[WIDX_W-1:0]};
          word_q     <= word_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pxs_shifter.sv
module pxs_shifter #(
  parameter int WORD_W  = 16,
  parameter int PHASE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blank,
  input  logic              line_start,
  input  logic              fetch_req,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data,
  output logic              load_tick,
  output logic              pix_out,
  output logic              underrun
);

  logic [WORD_W-1:0]  hold_q;
  logic               hold_full_q;
  logic [WORD_W-1:0]  shift_q;
  logic [PHASE_W-1:0] phase_q;
  logic [1:0]         pending_q;
  logic               drop_q;
  logic               starve;

  assign load_tick = !blank && (phase_q == '0);
  assign starve    = load_tick && !hold_full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      shift_q     <= '0;
      phase_q     <= '0;
      pending_q   <= '0;
      drop_q      <= 1'b0;
      pix_out     <= 1'b0;
      underrun    <= 1'b0;
    end else begin
      underrun  <= 1'b0;
      pending_q <= pending_q + {1'b0, fetch_req} - {1'b0, rd_valid};

      // Serial side
      if (blank) begin
        pix_out <= 1'b0;
        phase_q <= '0;
      end else if (load_tick) begin
        phase_q <= phase_q + 1'b1;
        if (hold_full_q) begin
          pix_out     <= hold_q[WORD_W-1];
          shift_q     <= {hold_q[WORD_W-2:0], 1'b0};
          hold_full_q <= 1'b0;
        end else begin
          pix_out  <= 1'b0;
          shift_q  <= '0;
          underrun <= 1'b1;
          if (!rd_valid && pending_q != '0) drop_q <= 1'b1;
        end
      end else begin
        phase_q <= phase_q + 1'b1;
        pix_out <= shift_q[WORD_W-1];
        shift_q <= {shift_q[WORD_W-2:0], 1'b0};
      end

      // Memory side: accept in-time data, discard late data
      if (rd_valid) begin
        if (drop_q) begin
          drop_q <= 1'b0;
        end else if (!starve) begin
          hold_q      <= rd_data;
          hold_full_q <= 1'b1;
        end
      end

      if (line_start) begin
        hold_full_q <= 1'b0;
        drop_q      <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pixel_word_serializer.sv
module pixel_word_serializer #(
  parameter  int WORD_W   = 16,
  parameter  int LINE_PIX = 1024,
  parameter  int LINES    = 1024,
  localparam int WORDS    = LINE_PIX / WORD_W,
  localparam int WIDX_W   = pxs_pkg::idx_width(WORDS),
  localparam int LIDX_W   = pxs_pkg::idx_width(LINES),
  localparam int ADDR_W   = LIDX_W + WIDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              blank,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data,
  output logic              pix_out,
  output logic              underrun
);

  localparam int PHASE_W = pxs_pkg::idx_width(WORD_W);

  logic load_tick;

  pxs_fetch_seq #(
    .WORDS (WORDS),
    .LINES (LINES),
    .WIDX_W(WIDX_W),
    .LIDX_W(LIDX_W)
  ) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .line_start (line_start),
    .load_tick  (load_tick),
    .fetch_req  (fetch_req),
    .fetch_addr (fetch_addr)
  );

  pxs_shifter #(
    .WORD_W (WORD_W),
    .PHASE_W(PHASE_W)
  ) u_shift (
    .clk       (clk),
    .rst       (rst),
    .blank     (blank),
    .line_start(line_start),
    .fetch_req (fetch_req),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .load_tick (load_tick),
    .pix_out   (pix_out),
    .underrun  (underrun)
  );

endmodule

// File: rtl/pxs_checker.sv
module pxs_checker #(
  parameter int ADDR_W = 16,
  parameter int WIDX_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              line_start,
  input logic              blank,
  input logic              fetch_req,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              pix_out,
  input logic              underrun
);

  // R8
  p_reset_quiet_r8: assert property (@(posedge clk)
    rst |=> (!fetch_req && !pix_out && !underrun));

  // R4
  p_blank_dark_r4: assert property (@(posedge clk) disable iff (rst)
    blank |=> (!pix_out && !underrun));

  // R4
  p_blank_no_fetch_r4: assert property (@(posedge clk) disable iff (rst)
    (blank && !line_start) |=> !fetch_req);

  // R3
  p_line_prefetch_r3: assert property (@(posedge clk) disable iff (rst)
    line_start |=> (fetch_req && fetch_addr[WIDX_W-1:0] == '0));

  // R5
  p_underrun_dark_r5: assert property (@(posedge clk) disable iff (rst)
    underrun |-> !pix_out);

endmodule

bind pixel_word_serializer pxs_checker #(
  .ADDR_W(ADDR_W),
  .WIDX_W(WIDX_W)
) u_pxs_checker (
  .clk       (clk),
  .rst       (rst),
  .line_start(line_start),
  .blank     (blank),
  .fetch_req (fetch_req),
  .fetch_addr(fetch_addr),
  .pix_out   (pix_out),
  .underrun  (underrun)
);

// File: tb/pixel_word_serializer_bench.sv
`timescale 1ns/1ps
module pixel_word_serializer_bench;

  localparam int WORD_W   = 16;
  localparam int LINE_PIX = 64;
  localparam int LINES    = 4;
  localparam int WORDS    = LINE_PIX / WORD_W;
  localparam int ADDR_W   = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              frame_start = 1'b0;
  logic              line_start = 1'b0;
  logic              blank = 1'b1;
  logic              fetch_req;
  logic [ADDR_W-1:0] fetch_addr;
  logic              rd_valid = 1'b0;
  logic [WORD_W-1:0] rd_data = '0;
  logic              pix_out;
  logic              underrun;

  pixel_word_serializer #(
    .WORD_W(WORD_W), .LINE_PIX(LINE_PIX), .LINES(LINES)
  ) u_pixel_word_serializer (
    .clk(clk), .rst(rst), .frame_start(frame_start), .line_start(line_start),
    .blank(blank), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .pix_out(pix_out), .underrun(underrun)
  );

  always #5 clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cyc      = 0;
  int    lat      = 3;
  int    tb_line  = 0;
  int    fetch_idx = 0;
  string addr_tag = "R2";
  bit    done = 1'b0;

  bit exp_pix_q[$];
  bit exp_ur_q[$];
  int due_q[$];
  int addr_q[$];

  function automatic logic [WORD_W-1:0] word_of(input int a);
    logic [31:0] t;
    t = a * 40503 + 12345;
    return t[WORD_W-1:0] ^ 16'h5A3C;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  always @(posedge clk) cyc++;

  // Memory model: in-order responses after lat cycles; checks every request address.
  always @(negedge clk) begin
    rd_valid <= 1'b0;
    if (due_q.size() > 0 && due_q[0] <= cyc) begin
      int a;
      void'(due_q.pop_front());
      a = addr_q.pop_front();
      rd_valid <= 1'b1;
      rd_data  <= word_of(a);
    end
    if (!rst && fetch_req) begin
      // R2 (and R6 / R7 via addr_tag): address = line above word index
      check(int'(fetch_addr) == tb_line * WORDS + fetch_idx, addr_tag,
            int'(fetch_addr), tb_line * WORDS + fetch_idx);
      fetch_idx++;
      due_q.push_back(cyc + lat);
      addr_q.push_back(int'(fetch_addr));
    end
  end

  // Monitor: scoreboard compare one clock after each dot
  always @(posedge clk) begin
    bit vis;
    bit act_rst;
    vis = !blank;
    act_rst = rst;
    #1;
    if (!act_rst) begin
      if (vis) begin
        if (exp_pix_q.size() == 0) begin
          check(1'b0, "R1 R9 queue empty", 0, 1);
        end else begin
          bit ep;
          bit eu;
          ep = exp_pix_q.pop_front();
          eu = exp_ur_q.pop_front();
          check(pix_out == ep, "R1 R9 pixel", int'(pix_out), int'(ep));
          check(underrun == eu, "R5 underrun", int'(underrun), int'(eu));
        end
      end else begin
        check(pix_out == 1'b0 && underrun == 1'b0, "R4 blank dark",
              int'({pix_out, underrun}), 0);
      end
    end
  end

  task automatic run_line(input bit fs, input bit slow, input int line_idx, input string tag);
    @(negedge clk);
    line_start = 1'b1;
    frame_start = fs;
    tb_line = line_idx;
    fetch_idx = 0;
    addr_tag = tag;
    lat = slow ? 20 : 3;
    @(negedge clk);
    line_start = 1'b0;
    frame_start = 1'b0;
    // R3: prefetch strobe right after line_start, word index zero
    check(fetch_req == 1'b1, "R3 prefetch strobe", int'(fetch_req), 1);
    check(fetch_addr[1:0] == 2'b00, "R3 word index zero", int'(fetch_addr[1:0]), 0);
    @(negedge clk);
    check(fetch_req == 1'b0, "R3 single-cycle strobe", int'(fetch_req), 0);
    repeat (27) @(negedge clk);
    for (int d = 0; d < LINE_PIX; d++) begin
      logic [WORD_W-1:0] w;
      bit late;
      if (d > 0) @(negedge clk);
      blank = 1'b0;
      w = word_of(line_idx * WORDS + d / WORD_W);
      late = slow && (d >= WORD_W);
      exp_pix_q.push_back(late ? 1'b0 : w[WORD_W-1 - (d % WORD_W)]);
      exp_ur_q.push_back(late && (d % WORD_W == 0));
    end
    @(negedge clk);
    blank = 1'b1;
    repeat (30) @(negedge clk);
    // R2 / R4: exactly one fetch per word, none during blanking
    check(fetch_idx == WORDS, "R2 R4 fetch count", fetch_idx, WORDS);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check(fetch_req == 1'b0 && pix_out == 1'b0 && underrun == 1'b0, "R8 reset",
          int'({fetch_req, pix_out, underrun}), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(fetch_req == 1'b0, "R8 idle after reset", int'(fetch_req), 0);
    run_line(1'b0, 1'b0, 0, "R2");
    run_line(1'b0, 1'b1, 1, "R6");   // R5 slow memory line
    run_line(1'b0, 1'b0, 2, "R6");   // late words from line 1 must not show
    run_line(1'b0, 1'b0, 3, "R6");
    run_line(1'b0, 1'b0, 0, "R6");   // wrap after LINES-1
    run_line(1'b0, 1'b0, 1, "R6");
    run_line(1'b1, 1'b0, 0, "R7");   // frame restart
    run_line(1'b0, 1'b0, 1, "R6");
    check(exp_pix_q.size() == 0, "R1 all pixels seen", exp_pix_q.size(), 0);
    finish_run();
  end

  initial begin
    #2000000;
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

endmodule